// File: doc/BRIEF.md
# Full-Bridge Gate Command Decoder with Crossover Dead Time

This block turns the control pins of a brushed DC motor bridge into on/off commands for the four power switches of a full bridge. The inputs are the direction bit, the drive enable, the decay-mode select, the active-low standby pin, the state of the current chopper (active flag and recirculation sub-phase), a near-zero-current flag and a fault kill from the protection supervisor. For each output leg, the block works out whether that output should be high, low or high-impedance. A per-leg state machine then produces the high-side and low-side gate enables.

The decoder first classifies the inputs into one operation: `OP_STANDBY`, `OP_DRIVE`, `OP_CHOP`, `OP_BRAKE` or `OP_FAST`. Each leg state machine has four states: `LEG_OFF`, `LEG_HIGH`, `LEG_LOW` and `LEG_DEAD`. Its transitions are:

- off-to-high (`LEG_OFF`→`LEG_HIGH`) and off-to-low (`LEG_OFF`→`LEG_LOW`), taken at once.
- leave-high and leave-low (`LEG_HIGH`/`LEG_LOW`→`LEG_DEAD`), taken on any change of target.
- dead-expire (`LEG_DEAD`→ target state) once the counter reaches zero.
- fault-kill, from any state to `LEG_DEAD` with the counter reloaded.

A gate is never turned on straight out of the opposite side. It always passes through `DEAD_CYC` cycles in which both switches of the leg are off.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With `sby_n`=1, `en_in`=1 and `chop_act`=0, the settled outputs are as follows. If `phase_in`=1, leg 0 is high and leg 1 is low. If `phase_in`=0, leg 0 is low and leg 1 is high. A leg is high when only `hs_on` is 1, low when only `ls_on` is 1, and Hi-Z when both are 0.
- R2: With `en_in`=0 and `mode_in`=1, both legs settle high (brake), for either value of `phase_in`.
- R3: With `en_in`=0, `mode_in`=0 and `i_near_zero`=0, the bridge is in synchronous fast decay. If `phase_in`=1, leg 0 is low and leg 1 is high. If `phase_in`=0, leg 0 is high and leg 1 is low.
- R4: With `en_in`=1 and `chop_act`=1, the leg opposite the driven one stays high, and the driven leg follows `chop_recirc` (1 gives high, 0 gives low). The driven leg is leg 0 when `phase_in`=1 and leg 1 when `phase_in`=0.
- R5: In fast decay, both legs settle Hi-Z when `i_near_zero`=1. Fast decay here means either `en_in`=0 with `mode_in`=0, or the chop sub-phase with `chop_recirc`=0.
- R6: With `sby_n`=0, all four gate enables are 0 by the sample after the first clock edge that sees it, whatever the other inputs are.
- R7: When a leg's target changes from one side to the other, the leg's gates are both 0 for exactly `DEAD_CYC` cycles before the opposite gate turns on.
- R8: A leg in `LEG_OFF` turns on the requested gate at the first clock edge that samples the new target, with no dead time.
- R9: `flt_off`=1 clears all four gate enables in the same cycle. After it drops, no gate turns on before the `DEAD_CYC`-th clock edge following the release.
- R10: `hs_on[i]` and `ls_on[i]` are never 1 in the same cycle.
- R11: While `rst_n`=0, all gate enables are 0, and every leg starts in `LEG_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sby_n | input | 1 | Active-low standby; low forces both outputs Hi-Z |
| phase_in | input | 1 | Direction select |
| en_in | input | 1 | Drive enable |
| mode_in | input | 1 | Decay select when enable is low: 1 brake, 0 fast decay |
| chop_act | input | 1 | Current chopper in its off-time |
| chop_recirc | input | 1 | Chop sub-phase: 1 slow recirculation, 0 fast |
| i_near_zero | input | 1 | Load current close to zero |
| flt_off | input | 1 | Supervisor fault kill, all gates off |
| hs_on | output | 2 | High-side gate enable per leg |
| ls_on | output | 2 | Low-side gate enable per leg |

## Verification
The assertions take for granted several things about the inputs. Every input is driven to a known level from time zero. `flt_off` and `sby_n` change only between clock edges. The standby check assumes standby has been low for two consecutive samples. The dead-time checks assume `DEAD_CYC` is at least 1.

The stimulus keeps within these limits. It changes inputs only half a cycle after the active edge. It holds each random pattern for 1 to 50 cycles, so legs both settle and get interrupted in the middle of a dead time. It keeps faults and standby rare enough that the drive, chop and decay operations all occur often.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        LVL_Z  = 2'd0,
        LVL_LO = 2'd1,
        LVL_HI = 2'd2
    } lvl_t;

    typedef enum logic [2:0] {
        OP_STANDBY = 3'd0,
        OP_DRIVE   = 3'd1,
        OP_CHOP    = 3'd2,
        OP_BRAKE   = 3'd3,
        OP_FAST    = 3'd4
    } op_t;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2,
        LEG_DEAD = 2'd3
    } leg_st_t;
endpackage

// File: rtl/hbg_mode_decode.sv
`timescale 1ns/1ps
module hbg_mode_decode
    import hbg_pkg::*;
(
    input  logic sby_n,
    input  logic phase_in,
    input  logic en_in,
    input  logic mode_in,
    input  logic chop_act,
    input  logic chop_recirc,
    input  logic i_near_zero,
    output lvl_t lvl_a,
    output lvl_t lvl_b
);
    op_t op;

    // Operation classification, standby has top priority
    always_comb begin
        if (!sby_n)
            op = OP_STANDBY;
        else if (en_in)
            op = chop_act ? OP_CHOP : OP_DRIVE;
        else
            op = mode_in ? OP_BRAKE : OP_FAST;
    end

    // Per-leg target levels for each operation
    always_comb begin
        lvl_a = LVL_Z;
        lvl_b = LVL_Z;
        unique case (op)
            OP_STANDBY: begin
                lvl_a = LVL_Z;
                lvl_b = LVL_Z;
            end
            OP_DRIVE: begin
                lvl_a = phase_in ? LVL_HI : LVL_LO;
                lvl_b = phase_in ? LVL_LO : LVL_HI;
            end
            OP_CHOP: begin
                if (!chop_recirc && i_near_zero) begin
                    lvl_a = LVL_Z;
                    lvl_b = LVL_Z;
                end else if (phase_in) begin
                    lvl_a = chop_recirc ? LVL_HI : LVL_LO;
                    lvl_b = LVL_HI;
                end else begin
                    lvl_a = LVL_HI;
                    lvl_b = chop_recirc ? LVL_HI : LVL_LO;
                end
            end
            OP_BRAKE: begin
                lvl_a = LVL_HI;
                lvl_b = LVL_HI;
            end
            OP_FAST: begin
                if (i_near_zero) begin
                    lvl_a = LVL_Z;
                    lvl_b = LVL_Z;
                end else begin
                    lvl_a = phase_in ? LVL_LO : LVL_HI;
                    lvl_b = phase_in ? LVL_HI : LVL_LO;
                end
            end
            default: begin
                lvl_a = LVL_Z;
                lvl_b = LVL_Z;
            end
        endcase
    end
endmodule

// File: rtl/hbg_leg_fsm.sv
`timescale 1ns/1ps
module hbg_leg_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  lvl_t tgt,
    input  logic kill,
    output logic hs,
    output logic ls
);
    localparam int CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC - 1);

    leg_st_t          st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LEG_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        if (kill) begin
            st_nxt  = LEG_DEAD;
            cnt_nxt = CNT_LOAD;
        end else begin
            unique case (st)
                LEG_OFF: begin
                    if (tgt == LVL_HI)      st_nxt = LEG_HIGH;
                    else if (tgt == LVL_LO) st_nxt = LEG_LOW;
                end
                LEG_HIGH: begin
                    if (tgt != LVL_HI) begin
                        st_nxt  = LEG_DEAD;
                        cnt_nxt = CNT_LOAD;
                    end
                end
                LEG_LOW: begin
                    if (tgt != LVL_LO) begin
                        st_nxt  = LEG_DEAD;
                        cnt_nxt = CNT_LOAD;
                    end
                end
                LEG_DEAD: begin
                    if (cnt == '0) begin
                        if (tgt == LVL_HI)      st_nxt = LEG_HIGH;
                        else if (tgt == LVL_LO) st_nxt = LEG_LOW;
                        else                    st_nxt = LEG_OFF;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
                default: st_nxt = LEG_DEAD;
            endcase
        end
    end

    // Outputs: state decode, fault kill acts without a clock edge
    always_comb begin
        hs = (st == LEG_HIGH) && !kill;
        ls = (st == LEG_LOW)  && !kill;
    end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 35
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sby_n,
    input  logic                phase_in,
    input  logic                en_in,
    input  logic                mode_in,
    input  logic                chop_act,
    input  logic                chop_recirc,
    input  logic                i_near_zero,
    input  logic                flt_off,
    output logic [NUM_LEGS-1:0] hs_on,
    output logic [NUM_LEGS-1:0] ls_on
);
    lvl_t lvl_a, lvl_b;
    lvl_t leg_tgt [NUM_LEGS];

    hbg_mode_decode u_dec (
        .sby_n       (sby_n),
        .phase_in    (phase_in),
        .en_in       (en_in),
        .mode_in     (mode_in),
        .chop_act    (chop_act),
        .chop_recirc (chop_recirc),
        .i_near_zero (i_near_zero),
        .lvl_a       (lvl_a),
        .lvl_b       (lvl_b)
    );

    assign leg_tgt[0] = lvl_a;
    assign leg_tgt[1] = lvl_b;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg_fsm #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .tgt   (leg_tgt[g]),
            .kill  (flt_off),
            .hs    (hs_on[g]),
            .ls    (ls_on[g])
        );
    end
endmodule

// File: rtl/hbg_checker.sv
`timescale 1ns/1ps
module hbg_checker #(
    parameter int DEAD_CYC = 35
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sby_n,
    input logic       flt_off,
    input logic [1:0] hs_on,
    input logic [1:0] ls_on
);
    localparam int GW = $clog2(DEAD_CYC + 1);

    // R10
    no_overlap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on[0] && ls_on[0]));
    // R10
    no_overlap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on[1] && ls_on[1]));
    // R9
    fault_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_off |-> (hs_on == 2'b00 && ls_on == 2'b00));
    // R6
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sby_n && $past(!sby_n)) |-> (hs_on == 2'b00 && ls_on == 2'b00));

    for (genvar g = 0; g < 2; g++) begin : g_dead
        logic [GW-1:0] gap;
        logic [1:0]    last_side;  // 0 none, 1 high, 2 low
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap       <= '0;
                last_side <= 2'd0;
            end else if (hs_on[g] || ls_on[g]) begin
                gap       <= '0;
                last_side <= hs_on[g] ? 2'd1 : 2'd2;
            end else if (gap < GW'(DEAD_CYC)) begin
                gap <= gap + 1'b1;
            end
        end
        // R7
        dead_hi_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ls_on[g]) && last_side == 2'd1) |-> (gap >= GW'(DEAD_CYC)));
        // R7
        dead_lo_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(hs_on[g]) && last_side == 2'd2) |-> (gap >= GW'(DEAD_CYC)));
    end
endmodule

bind hbridge_gate_ctrl hbg_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sby_n   (sby_n),
    .flt_off (flt_off),
    .hs_on   (hs_on),
    .ls_on   (ls_on)
);

// File: tb/hbridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_test;
    localparam int DC = 35;
    localparam int ZZ = 0, LO = 1, HI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sby, ph, en, md, ch, rc, iz, flt;
    logic [1:0] hs_on, ls_on;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 0;
    bit done = 0;

    int m_st [2];   // 0 off, 1 high, 2 low, 3 dead
    int m_cnt [2];

    always #5 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(DC)) uut (
        .clk(clk), .rst_n(rst_n), .sby_n(sby), .phase_in(ph), .en_in(en),
        .mode_in(md), .chop_act(ch), .chop_recirc(rc), .i_near_zero(iz),
        .flt_off(flt), .hs_on(hs_on), .ls_on(ls_on)
    );

    function automatic int exp_lvl(int leg);
        int drv;
        if (!sby) return ZZ;
        if (en) begin
            if (!ch) return (((leg == 0) ? 1'b1 : 1'b0) == ph) ? HI : LO;
            if (!rc && iz) return ZZ;
            drv = ph ? 0 : 1;
            if (leg == drv) return rc ? HI : LO;
            return HI;
        end
        if (md) return HI;
        if (iz) return ZZ;
        return (((leg == 0) ? 1'b1 : 1'b0) == ph) ? LO : HI;
    endfunction

    function automatic int dut_lvl(int leg);
        if (hs_on[leg]) return HI;
        if (ls_on[leg]) return LO;
        return ZZ;
    endfunction

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Reference timing model of one leg
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            int t;
            t = exp_lvl(i);
            if (!rst_n) begin
                m_st[i] <= 0; m_cnt[i] <= 0;
            end else if (flt) begin
                m_st[i] <= 3; m_cnt[i] <= DC - 1;
            end else if (m_st[i] == 0) begin
                m_st[i] <= (t == HI) ? 1 : (t == LO) ? 2 : 0;
            end else if (m_st[i] == 1 || m_st[i] == 2) begin
                if (t != ((m_st[i] == 1) ? HI : LO)) begin
                    m_st[i] <= 3; m_cnt[i] <= DC - 1;
                end
            end else if (m_cnt[i] == 0) begin
                m_st[i] <= (t == HI) ? 1 : (t == LO) ? 2 : 0;
            end else begin
                m_cnt[i] <= m_cnt[i] - 1;
            end
        end
    end

    // Per-cycle comparison with the model, plus the overlap rule
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = 0; i < 2; i++) begin
                chk("R7 model hs", int'(hs_on[i]), int'(m_st[i] == 1 && !flt));
                chk("R7 model ls", int'(ls_on[i]), int'(m_st[i] == 2 && !flt));
                chk("R10 overlap", int'(hs_on[i] && ls_on[i]), 0);
            end
        end
    end

    task automatic drive(logic s, logic p, logic e, logic m, logic c,
                         logic r, logic z, logic f);
        @(negedge clk); #1;
        sby = s; ph = p; en = e; md = m; ch = c; rc = r; iz = z; flt = f;
    endtask

    task automatic settle(string tag);
        repeat (DC + 3) @(negedge clk);
        chk({tag, " leg0"}, dut_lvl(0), exp_lvl(0));
        chk({tag, " leg1"}, dut_lvl(1), exp_lvl(1));
    endtask

    task automatic count_off(int leg, output int n);
        n = 0;
        for (int k = 0; k < 4 * DC; k++) begin
            @(negedge clk);
            if (hs_on[leg] || ls_on[leg]) break;
            n++;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd5150));
        sby = 1; ph = 1; en = 1; md = 0; ch = 0; rc = 0; iz = 0; flt = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset hs", int'(hs_on), 0);
        chk("R11 reset ls", int'(ls_on), 0);
        sby = 0;
        @(negedge clk); #1; rst_n = 1;
        @(negedge clk);
        mon_on = 1;
        chk("R11 idle after reset", int'(hs_on | ls_on), 0);

        // R8: from off, gate on one edge after request
        drive(1, 1, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R8 no dead from off", int'(hs_on[0]), 1);
        settle("R1 forward");

        // R7: side swap counts exactly DC off samples
        drive(1, 0, 1, 0, 0, 0, 0, 0);
        count_off(0, n);
        chk("R7 dead length", n, DC);
        settle("R1 reverse");

        drive(1, 0, 0, 1, 0, 0, 0, 0); settle("R2 brake ph0");
        drive(1, 1, 0, 1, 0, 0, 0, 0); settle("R2 brake ph1");
        drive(1, 1, 0, 0, 0, 0, 0, 0); settle("R3 fast ph1");
        drive(1, 0, 0, 0, 0, 0, 0, 0); settle("R3 fast ph0");
        drive(1, 1, 1, 0, 1, 1, 0, 0); settle("R4 chop ph1 slow");
        drive(1, 1, 1, 0, 1, 0, 0, 0); settle("R4 chop ph1 fast");
        drive(1, 0, 1, 0, 1, 1, 0, 0); settle("R4 chop ph0 slow");
        drive(1, 0, 1, 0, 1, 0, 0, 0); settle("R4 chop ph0 fast");
        drive(1, 0, 0, 0, 0, 0, 1, 0); settle("R5 fast zero current");
        drive(1, 1, 1, 0, 1, 0, 1, 0); settle("R5 chop zero current");
        drive(1, 1, 1, 0, 1, 1, 1, 0); settle("R4 slow ignores zero flag");

        // R6 standby overrides drive
        drive(1, 1, 1, 0, 0, 0, 0, 0); settle("R1 before standby");
        drive(0, 1, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 standby off", int'(hs_on | ls_on), 0);
        settle("R6 standby settled");

        // R9 fault kill and release
        drive(1, 1, 1, 0, 0, 0, 0, 0); settle("R1 before fault");
        drive(1, 1, 1, 0, 0, 0, 0, 1);
        #1;
        chk("R9 immediate kill", int'(hs_on | ls_on), 0);
        repeat (4) @(negedge clk);
        drive(1, 1, 1, 0, 0, 0, 0, 0);
        count_off(0, n);
        chk("R9 release wait", n, DC - 1);

        // Random segments
        for (int seg = 0; seg < 1500; seg++) begin
            logic f, s;
            f = ($urandom_range(15) == 0);
            s = ($urandom_range(9) != 0);
            drive(s, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom_range(3) == 0), f);
            repeat ($urandom_range(50, 1)) @(negedge clk);
        end
        drive(1, 1, 0, 1, 0, 0, 0, 0); settle("R2 final brake");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule